// File: doc/BRIEF.md
# Segmented int8 matrix multiply-accumulate unit

This block is a pipelined vector execution unit for small integer matrix products. It takes three vectors of VL bits, where VL is a parameter and a multiple of 128. Two of the vectors carry 8-bit integers and the third carries 32-bit accumulators. The block cuts every vector into 128-bit segments and works on each segment on its own. In a segment, the sixteen bytes of the left operand form a 2-row by 8-column matrix. The sixteen bytes of the right operand form an 8-row by 2-column matrix. The block multiplies the two, widens the 2x2 product to 32 bits, adds the four accumulator words of the same segment, and returns the full VL-bit sum.

Each operand has its own signedness control, so the unit can run signed-by-signed, unsigned-by-unsigned or mixed products. There is no predicate: every output word is written on every operation. A valid/ready pair on each side carries operations in and results out. When the consumer is ready, the unit accepts one operation per clock, and each result appears exactly three cycles after its operation was accepted.

Top module: `seg_mmla_unit`

## Requirements
- R1: The vectors split into VL/128 segments. Output segment s depends only on segment s of the left operand, the right operand and the accumulator. Segment s occupies bits [128*s+127 : 128*s].
- R2: Inside a segment, byte n sits at bits [8n+7:8n] and accumulator word w sits at bits [32w+31:32w]. Result word (2*i + j), for i and j in 0..1, equals accumulator word (2*i + j) plus the sum over k = 0..7 of left byte (8*i + k) times right byte (8*j + k).
- R3: With a_unsigned = 1 the left bytes are zero-extended, and with a_unsigned = 0 they are sign-extended. b_unsigned does the same for the right bytes. All four combinations are supported.
- R4: Every 8x8 product is exact, including the extremes -128 * -128 = 16384, 255 * 255 = 65025 and -128 * 255 = -32640.
- R5: The final 32-bit addition wraps modulo 2^32 with no saturation.
- R6: Every word of the result is produced on every operation; no word keeps an earlier value or the accumulator unchanged by rule.
- R7: With out_ready held high, out_valid rises exactly 3 clock edges after the edge that accepted an operation (in_valid and in_ready both high). One operation can be accepted on every cycle, and none is lost or duplicated.
- R8: While out_valid is 1 and out_ready is 0, in_ready is 0, and on the next edge out_valid stays 1 and result is unchanged.
- R9: A clock edge with rst_n = 0 leaves out_valid at 0 and discards operations in flight. After reset, with no pending result, in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit accepts the offered operation on this edge |
| a_unsigned | input | 1 | 1: left operand bytes are unsigned; 0: signed |
| b_unsigned | input | 1 | 1: right operand bytes are unsigned; 0: signed |
| src_a | input | VL | Left operand, 2x8 byte matrix per segment |
| src_b | input | VL | Right operand, 8x2 byte matrix per segment, columns stored contiguously |
| acc_in | input | VL | Accumulator, four 32-bit words per segment |
| out_valid | output | 1 | result holds a finished operation |
| out_ready | input | 1 | Consumer takes the result on this edge |
| result | output | VL | Accumulator plus matrix product, four 32-bit words per segment |

## Verification
Random vectors whose bytes lean towards 0x80, 0x7F, 0xFF and 0x00 are run under all four signedness settings. An all-0xFF operand yields 8 when read as signed and 520200 when read as unsigned, so a wrong extension shows up at once. A single pair of one-hot bytes with an otherwise zero matrix, and a vector with only one segment loaded, reveal any swapped row, column or segment index. Accumulators near 0x7FFFFFFF and 0xFFFFFFFF force wraparound. The same stimulus drives copies at VL 128, 256 and 512 to show that segment count scales cleanly. Directed timing sequences measure the three-cycle latency, back-to-back issue and holding of the result under backpressure.

// File: rtl/mmla_pkg.sv
// Package: shared widths and the byte-widening helper of the int8 matrix MAC.
// Assumes a 128-bit segment holding 16 bytes or 4 words.
package mmla_pkg;
    localparam int SEG_W  = 128;
    localparam int BYTE_W = 8;
    localparam int ACC_W  = 32;
    localparam int DEPTH  = 8;                 // dot-product length
    localparam int ELEMS  = 4;                 // 2x2 outputs per segment
    localparam int EXT_W  = BYTE_W + 1;        // byte widened with its sign choice
    localparam int PROD_W = 2 * BYTE_W + 1;    // exact 8x8 product in all modes
    localparam int SUM_W  = PROD_W + $clog2(DEPTH);

    // Widen one byte to a signed value: zero-extend when unsigned, else sign-extend.
    function automatic logic signed [EXT_W-1:0] widen_byte(input logic [BYTE_W-1:0] b,
                                                          input logic is_uns);
        return is_uns ? $signed({1'b0, b}) : $signed({b[BYTE_W-1], b});
    endfunction
endpackage

// File: rtl/mmla_mul8.sv
// Module: one exact 8x8 multiplier with per-operand signedness.
// Assumes PROD_W is wide enough for 255*255 and -128*255 (17 bits).
module mmla_mul8
    import mmla_pkg::*;
(
    input  logic [BYTE_W-1:0]        a_byte,
    input  logic [BYTE_W-1:0]        b_byte,
    input  logic                     a_uns,
    input  logic                     b_uns,
    output logic signed [PROD_W-1:0] prod
);
    logic signed [EXT_W-1:0] ea;
    logic signed [EXT_W-1:0] eb;

    // Widen both bytes and form the signed product at full width.
    always_comb begin
        ea   = widen_byte(a_byte, a_uns);
        eb   = widen_byte(b_byte, b_uns);
        prod = PROD_W'(ea) * PROD_W'(eb);
    end
endmodule

// File: rtl/mmla_dot_tree.sv
// Module: balanced binary adder tree summing N signed products.
// Assumes N is a power of two and SUM_W has log2(N) guard bits.
module mmla_dot_tree
    import mmla_pkg::*;
#(
    parameter int N = DEPTH
) (
    input  logic signed [PROD_W-1:0] terms [N],
    output logic signed [SUM_W-1:0]  sum
);
    localparam int NODES = 2 * N - 1;

    logic signed [SUM_W-1:0] node [NODES];

    // Leaves: sign-extend every product into the tree width.
    for (genvar i = 0; i < N; i++) begin : g_leaf
        assign node[N-1+i] = SUM_W'(terms[i]);
    end

    // Inner nodes: each adds its two children.
    for (genvar i = 0; i < N - 1; i++) begin : g_inner
        assign node[i] = node[2*i+1] + node[2*i+2];
    end

    assign sum = node[0];
endmodule

// File: rtl/mmla_segment.sv
// Module: three-stage datapath for one 128-bit segment (multiply, tree, accumulate).
// Assumes the caller provides one shared enable for all stages; data regs are not reset.
module mmla_segment
    import mmla_pkg::*;
(
    input  logic             clk,
    input  logic             en,
    input  logic             a_uns,
    input  logic             b_uns,
    input  logic [SEG_W-1:0] a_seg,
    input  logic [SEG_W-1:0] b_seg,
    input  logic [SEG_W-1:0] acc_seg,
    output logic [SEG_W-1:0] res_seg
);
    logic signed [PROD_W-1:0] prod_d [ELEMS][DEPTH];
    logic signed [PROD_W-1:0] prod_q [ELEMS][DEPTH];
    logic signed [SUM_W-1:0]  sum_d  [ELEMS];
    logic signed [SUM_W-1:0]  sum_q  [ELEMS];
    logic [SEG_W-1:0]         acc1_q;
    logic [SEG_W-1:0]         acc2_q;
    logic [SEG_W-1:0]         res_q;

    // Multipliers: element e = 2*i + j pairs left row i with right column j.
    for (genvar e = 0; e < ELEMS; e++) begin : g_elem
        localparam int ROW = e / 2;
        localparam int COL = e % 2;
        for (genvar k = 0; k < DEPTH; k++) begin : g_term
            mmla_mul8 u_mul (
                .a_byte (a_seg[(DEPTH*ROW+k)*BYTE_W +: BYTE_W]),
                .b_byte (b_seg[(DEPTH*COL+k)*BYTE_W +: BYTE_W]),
                .a_uns  (a_uns),
                .b_uns  (b_uns),
                .prod   (prod_d[e][k])
            );
        end
        mmla_dot_tree #(.N(DEPTH)) u_tree (
            .terms (prod_q[e]),
            .sum   (sum_d[e])
        );
    end

    // Stage 1: register products and carry the accumulator along.
    always_ff @(posedge clk) begin
        if (en) begin
            prod_q <= prod_d;
            acc1_q <= acc_seg;
        end
    end

    // Stage 2: register the tree sums and the accumulator.
    always_ff @(posedge clk) begin
        if (en) begin
            sum_q  <= sum_d;
            acc2_q <= acc1_q;
        end
    end

    // Stage 3: wrap-around 32-bit accumulate of each word.
    always_ff @(posedge clk) begin
        if (en) begin
            for (int e = 0; e < ELEMS; e++) begin
                res_q[e*ACC_W +: ACC_W] <= acc2_q[e*ACC_W +: ACC_W] + ACC_W'(sum_q[e]);
            end
        end
    end

    assign res_seg = res_q;
endmodule

// File: rtl/seg_mmla_unit.sv
// Module: top of the segmented int8 matrix MAC; splits the vectors into segments
// and runs a shared three-deep valid pipeline with a global stall on backpressure.
// Assumes VL is a positive multiple of 128.
module seg_mmla_unit
    import mmla_pkg::*;
#(
    parameter int VL = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          a_unsigned,
    input  logic          b_unsigned,
    input  logic [VL-1:0] src_a,
    input  logic [VL-1:0] src_b,
    input  logic [VL-1:0] acc_in,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [VL-1:0] result
);
    localparam int NSEG   = VL / SEG_W;
    localparam int STAGES = 3;

    logic [STAGES-1:0] vld_q;
    logic              adv;

    // Pipeline moves unless a finished result waits for the consumer.
    assign adv       = !(vld_q[STAGES-1] && !out_ready);
    assign in_ready  = adv;
    assign out_valid = vld_q[STAGES-1];

    // Valid shift register, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (adv) begin
            vld_q <= {vld_q[STAGES-2:0], in_valid};
        end
    end

    // One datapath per 128-bit segment.
    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        mmla_segment u_seg (
            .clk     (clk),
            .en      (adv),
            .a_uns   (a_unsigned),
            .b_uns   (b_unsigned),
            .a_seg   (src_a [s*SEG_W +: SEG_W]),
            .b_seg   (src_b [s*SEG_W +: SEG_W]),
            .acc_seg (acc_in[s*SEG_W +: SEG_W]),
            .res_seg (result[s*SEG_W +: SEG_W])
        );
    end
endmodule

// File: rtl/mmla_checker.sv
// Module: protocol checker for seg_mmla_unit, attached by bind.
// Assumes it sees only the top-level ports.
module mmla_checker #(
    parameter int VL = 512
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [VL-1:0] result
);
    logic [2:0] inflight_q;
    logic       rst_seen_q;

    // Count accepted operations not yet delivered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight_q <= '0;
        end else begin
            inflight_q <= inflight_q + 3'(in_valid && in_ready) - 3'(out_valid && out_ready);
        end
    end

    // Remember that the previous edge was a reset edge.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    a_r8_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    a_r8_stall_holds_result: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(result)));

    a_r7_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q <= 3'd3);

    a_r7_no_spurious_output: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (inflight_q != 3'd0));

    a_r7_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    a_r6_result_known: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(result));

    a_r9_reset_clears_valid: assert property (@(posedge clk)
        rst_seen_q |-> !out_valid);
endmodule

bind seg_mmla_unit mmla_checker #(.VL(VL)) u_mmla_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .result    (result)
);

// File: tb/test_seg_mmla_unit.sv
// Bench: drives copies at VL 128, 256 and 512 from one stimulus and checks
// every delivered result against a behavioural reference.
module test_seg_mmla_unit;
    localparam int CLK_PERIOD = 10;
    localparam int MAXV       = 512;
    localparam int NINST      = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             a_uns = 1'b0;
    logic             b_uns = 1'b0;
    logic [MAXV-1:0]  src_a = '0;
    logic [MAXV-1:0]  src_b = '0;
    logic [MAXV-1:0]  acc_in = '0;
    logic             out_ready = 1'b1;
    logic             ir [NINST];
    logic             ov [NINST];
    logic [MAXV-1:0]  res_w [NINST];

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [MAXV-1:0] exp_q [$];
    string           tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar g = 0; g < NINST; g++) begin : g_vl
        localparam int W = 128 << g;
        logic [W-1:0] r;
        seg_mmla_unit #(.VL(W)) i_seg_mmla_unit (
            .clk        (clk),
            .rst_n      (rst_n),
            .in_valid   (in_valid),
            .in_ready   (ir[g]),
            .a_unsigned (a_uns),
            .b_unsigned (b_uns),
            .src_a      (src_a[W-1:0]),
            .src_b      (src_b[W-1:0]),
            .acc_in     (acc_in[W-1:0]),
            .out_valid  (ov[g]),
            .out_ready  (out_ready),
            .result     (r)
        );
        assign res_w[g] = MAXV'(r);
    end

    // Reference: per-segment 2x2 product of 8-byte rows and columns plus accumulator.
    function automatic logic [MAXV-1:0] ref_mmla(input logic [MAXV-1:0] a, b, c,
                                                 input logic ua, ub);
        logic [MAXV-1:0] r;
        for (int s = 0; s < MAXV/128; s++) begin
            for (int e = 0; e < 4; e++) begin
                int sum = 0;
                for (int k = 0; k < 8; k++) begin
                    logic [7:0] ab = a[s*128 + (8*(e/2)+k)*8 +: 8];
                    logic [7:0] bb = b[s*128 + (8*(e%2)+k)*8 +: 8];
                    int pa = ua ? int'({24'd0, ab}) : int'({{24{ab[7]}}, ab});
                    int pb = ub ? int'({24'd0, bb}) : int'({{24{bb[7]}}, bb});
                    sum += pa * pb;
                end
                r[s*128 + e*32 +: 32] = c[s*128 + e*32 +: 32] + 32'(sum);
            end
        end
        return r;
    endfunction

    function automatic logic [7:0] pick_byte();
        case ($urandom % 8)
            0: return 8'h80;
            1: return 8'h7F;
            2: return 8'hFF;
            3: return 8'h00;
            default: return 8'($urandom);
        endcase
    endfunction

    function automatic logic [MAXV-1:0] rand_bytes();
        logic [MAXV-1:0] v;
        for (int n = 0; n < MAXV/8; n++) v[n*8 +: 8] = pick_byte();
        return v;
    endfunction

    function automatic logic [MAXV-1:0] rand_acc();
        logic [MAXV-1:0] v;
        for (int n = 0; n < MAXV/32; n++) begin
            case ($urandom % 5)
                0: v[n*32 +: 32] = 32'h7FFF_FFFF;
                1: v[n*32 +: 32] = 32'hFFFF_FFFF;
                2: v[n*32 +: 32] = 32'h8000_0000;
                default: v[n*32 +: 32] = $urandom;
            endcase
        end
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [MAXV-1:0] act, input logic [MAXV-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, then score what the next rising edge takes.
    task automatic step(input logic iv, input logic ua, input logic ub,
                        input logic [MAXV-1:0] a, input logic [MAXV-1:0] b,
                        input logic [MAXV-1:0] c, input logic ordy, input string tag);
        @(negedge clk);
        in_valid  = iv;
        a_uns     = ua;
        b_uns     = ub;
        src_a     = a;
        src_b     = b;
        acc_in    = c;
        out_ready = ordy;
        #1;
        if (ov[NINST-1] && out_ready) begin
            logic [MAXV-1:0] exp;
            string t;
            if (exp_q.size() == 0) begin
                check(0, "R7", "result with nothing pending", res_w[NINST-1], '0);
            end else begin
                exp = exp_q.pop_front();
                t   = tag_q.pop_front();
                for (int g = 0; g < NINST; g++) begin
                    logic [MAXV-1:0] m = {MAXV{1'b1}} >> (MAXV - (128 << g));
                    check(ov[g] && ((res_w[g] & m) == (exp & m)), t,
                          $sformatf("result VL=%0d", 128 << g), res_w[g] & m, exp & m);
                end
            end
        end
        if (iv && ir[NINST-1]) begin
            exp_q.push_back(ref_mmla(a, b, c, ua, ub));
            tag_q.push_back(tag);
        end
    endtask

    task automatic idle(input logic ordy);
        step(1'b0, 1'b0, 1'b0, '0, '0, '0, ordy, "idle");
    endtask

    initial begin
        logic [MAXV-1:0] va, vb, vc, held;
        int qsz;
        void'($urandom(32'h1357_2468));

        // R9: reset state
        repeat (3) @(negedge clk);
        check(ov[NINST-1] == 1'b0, "R9", "out_valid in reset", MAXV'(ov[NINST-1]), '0);
        rst_n = 1'b1;
        #1;
        check(ir[NINST-1] == 1'b1, "R9", "in_ready after reset", MAXV'(ir[NINST-1]), MAXV'(1));

        // R7: latency of exactly 3 edges
        step(1'b1, 1'b0, 1'b0, rand_bytes(), rand_bytes(), rand_acc(), 1'b1, "R7");
        idle(1'b1);
        check(ov[NINST-1] == 1'b0, "R7", "out_valid after 1 edge", MAXV'(ov[NINST-1]), '0);
        idle(1'b1);
        check(ov[NINST-1] == 1'b0, "R7", "out_valid after 2 edges", MAXV'(ov[NINST-1]), '0);
        idle(1'b1);
        check(ov[NINST-1] == 1'b1, "R7", "out_valid after 3 edges", MAXV'(ov[NINST-1]), MAXV'(1));

        // R4 and R3: extremes under each signedness choice
        step(1'b1, 1'b0, 1'b0, {64{8'h80}}, {64{8'h80}}, '0, 1'b1, "R4 -128*-128");
        step(1'b1, 1'b1, 1'b1, {64{8'hFF}}, {64{8'hFF}}, '0, 1'b1, "R4 255*255");
        step(1'b1, 1'b0, 1'b1, {64{8'h80}}, {64{8'hFF}}, '0, 1'b1, "R4 -128*255");
        step(1'b1, 1'b0, 1'b0, {64{8'hFF}}, {64{8'hFF}}, '0, 1'b1, "R3 signed*signed");
        step(1'b1, 1'b1, 1'b0, {64{8'hFF}}, {64{8'hFF}}, '0, 1'b1, "R3 unsigned*signed");
        step(1'b1, 1'b0, 1'b1, {64{8'hFF}}, {64{8'h7F}}, '0, 1'b1, "R3 signed*unsigned");

        // R5: accumulator wraparound both ways
        step(1'b1, 1'b0, 1'b0, {64{8'h7F}}, {64{8'h7F}}, {16{32'h7FFF_FFFF}}, 1'b1, "R5 up");
        step(1'b1, 1'b0, 1'b0, {64{8'h80}}, {64{8'h7F}}, {16{32'h8000_0000}}, 1'b1, "R5 down");

        // R2: one-hot pair, left byte 3 (row 0,k=3) with right byte 11 (col 1,k=3)
        va = '0; vb = '0;
        va[3*8 +: 8] = 8'd1;
        vb[11*8 +: 8] = 8'd1;
        step(1'b1, 1'b0, 1'b0, va, vb, '0, 1'b1, "R2 one-hot");
        for (int n = 0; n < 64; n++) begin
            va[n*8 +: 8] = 8'(n + 1);
            vb[n*8 +: 8] = 8'(3 * n);
        end
        step(1'b1, 1'b1, 1'b1, va, vb, rand_acc(), 1'b1, "R2 index ramp");

        // R1: only segment 2 loaded; other segments must return the accumulator
        va = '0; vb = '0;
        va[2*128 +: 128] = rand_bytes();
        vb[2*128 +: 128] = rand_bytes();
        step(1'b1, 1'b0, 1'b0, va, vb, rand_acc(), 1'b1, "R1 single segment");

        // R6: zero operands, every word written with its accumulator
        vc = rand_acc();
        step(1'b1, 1'b0, 1'b0, '0, '0, vc, 1'b1, "R6 all words");
        repeat (4) idle(1'b1);

        // R8: backpressure holds result and blocks input
        step(1'b1, 1'b1, 1'b0, rand_bytes(), rand_bytes(), rand_acc(), 1'b1, "R8");
        idle(1'b0);
        idle(1'b0);
        idle(1'b0);
        check(ov[NINST-1] == 1'b1, "R8", "out_valid under stall", MAXV'(ov[NINST-1]), MAXV'(1));
        check(ir[NINST-1] == 1'b0, "R8", "in_ready under stall", MAXV'(ir[NINST-1]), '0);
        held = res_w[NINST-1];
        qsz  = exp_q.size();
        step(1'b1, 1'b0, 1'b0, rand_bytes(), rand_bytes(), rand_acc(), 1'b0, "R8 refused");
        check(res_w[NINST-1] == held, "R8", "result held", res_w[NINST-1], held);
        check(exp_q.size() == qsz, "R8", "offer refused", MAXV'(exp_q.size()), MAXV'(qsz));
        repeat (4) idle(1'b1);

        // R7: back-to-back issue with ready high, in_ready never drops
        for (int n = 0; n < 20; n++) begin
            step(1'b1, 1'($urandom), 1'($urandom), rand_bytes(), rand_bytes(), rand_acc(),
                 1'b1, "R7 back-to-back");
            check(ir[NINST-1] == 1'b1, "R7", "in_ready in stream", MAXV'(ir[NINST-1]), MAXV'(1));
        end
        repeat (4) idle(1'b1);

        // R1/R3/R5: constrained random mix with random backpressure
        for (int n = 0; n < 300; n++) begin
            step(1'(($urandom % 5) != 0), 1'($urandom), 1'($urandom), rand_bytes(),
                 rand_bytes(), rand_acc(), 1'(($urandom % 4) != 0), "R1/R3/R5 random");
        end
        for (int n = 0; n < 10; n++) idle(1'b1);
        check(exp_q.size() == 0, "R7", "all operations delivered", MAXV'(exp_q.size()), '0);

        // R9: reset discards an operation in flight
        step(1'b1, 1'b0, 1'b0, rand_bytes(), rand_bytes(), rand_acc(), 1'b1, "R9");
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_q.delete();
        tag_q.delete();
        for (int n = 0; n < 4; n++) begin
            idle(1'b1);
            check(ov[NINST-1] == 1'b0, "R9", "no output after reset", MAXV'(ov[NINST-1]), '0);
        end

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule